// File: doc/BRIEF.md
# Sampled-Clock Glitch Suppression Filter

This block cleans a slow serial line, such as the clock of a synchronous serial link, by removing narrow spikes of either polarity. Everything runs on one fast reference clock. A free-running binary counter provides sample strobes at one half, one quarter, one eighth and one sixteenth of the reference rate. Each strobe is a single reference cycle wide. A two-bit select picks one strobe, and its period P sets the rejection width.

The raw line first passes through a two-flop synchronizer. On each selected strobe, the synchronized level is shifted into a two-stage delay chain. The filtered output moves to a new level only when both stages hold that level, so a spike that is caught by at most one strobe never reaches the output.

The filter is meant for wanted pulses that are much wider than the interference. The price is a latency of a few sample periods on every real edge.

Top module: `spike_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output, the delay stages, the strobe counter and the applied select are all cleared to 0, whatever `line_raw` does.
- R2: `rate_sel` values 0, 1, 2 and 3 give a sample strobe period P of 2, 4, 8 and 16 reference cycles respectively. Each strobe is one cycle wide.
- R3: The raw line is passed through two reference-clock flops before sampling. The delay stages change only in cycles where the applied strobe is active.
- R4: The output changes level only in the cycle after both delay stages hold that new level. In every other cycle it keeps its previous value.
- R5: A high pulse on a low line that lasts fewer than P reference cycles produces no change on the output.
- R6: A low pulse on a high line that lasts fewer than P reference cycles produces no change on the output.
- R7: A pulse of either polarity that lasts 2P cycles or more appears on the output. The output then returns to the line's resting level.
- R8: Counting the edge that first captures a new raw level as edge 1, the output takes that level at edge n, where P+4 <= n <= 2P+3.
- R9: A new `rate_sel` value is applied only on the cycle in which the divide-by-16 strobe fires. Changing the select while the line is steady never produces an output edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all state is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_raw | input | 1 | Unfiltered serial line, asynchronous to clk_ref |
| rate_sel | input | 2 | Strobe divide select: 0 = /2, 1 = /4, 2 = /8, 3 = /16 |
| line_clean | output | 1 | Filtered line |

## Verification
The embedded properties cover the rules that hold every cycle. The delay stages move only on a strobe, and no strobe fires twice in a row. The applied select changes only at the divide-by-16 boundary. The output moves only after both stages agree on the new level. Rejection and passing of whole pulses, the exact latency window, and the absence of output edges while the select changes all depend on how the pulses line up with the strobes. Only the bench's scenarios can show these. It drives short and long pulses of both polarities at every divide setting.

// File: rtl/sf_pkg.sv
// Shared constants and types for the spike filter.
package sf_pkg;
    // Number of cascaded divide-by-two stages (gives /2 .. /16).
    localparam int unsigned DIV_STAGES  = 4;
    // Depth of the input synchronizer.
    localparam int unsigned SYNC_DEPTH  = 2;
    // Depth of the agreement delay chain.
    localparam int unsigned AGREE_DEPTH = 2;

    // Encoding of the divide select.
    typedef enum logic [1:0] {
        DIV_BY_2  = 2'd0,
        DIV_BY_4  = 2'd1,
        DIV_BY_8  = 2'd2,
        DIV_BY_16 = 2'd3
    } div_sel_e;
endpackage

// File: rtl/sf_sync.sv
// sf_sync: multi-flop synchronizer that brings the raw line into the
// reference clock domain.
// Assumes: the input may change at any time; the output is used only
// inside the clk_ref domain.
module sf_sync #(
    parameter int unsigned DEPTH = sf_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] ff_q;

    // Shift the raw level through DEPTH flops; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[DEPTH-2:0], din};
    end

    assign dout = ff_q[DEPTH-1];
endmodule

// File: rtl/sf_strobe_gen.sv
// sf_strobe_gen: cascaded binary divider.
// Stage k raises a one-cycle strobe every 2^(k+1) reference cycles.
// Assumes: STAGES >= 1. All strobes coincide on the cycle when the
// slowest one fires.
module sf_strobe_gen #(
    parameter int unsigned STAGES = sf_pkg::DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] stb
);
    logic [STAGES-1:0] cnt_q;

    // Free-running divide counter; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            // Stage k fires when all lower counter bits are set.
            assign stb[k] = &cnt_q[k:0];

            // R2
            strobe_single_cycle_chk: assert property (
                @(posedge clk) disable iff (!rst_n)
                stb[k] |=> !stb[k]
            );
        end
    endgenerate
endmodule

// File: rtl/sf_strobe_sel.sv
// sf_strobe_sel: picks one divider strobe.
// Assumes: stb_in[STAGES-1] is the slowest strobe and coincides with all
// the others. The select is re-applied only then, so a period is never cut
// short or stretched.
module sf_strobe_sel #(
    parameter int unsigned STAGES = sf_pkg::DIV_STAGES,
    localparam int unsigned SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] stb_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              stb_out
);
    logic [SEL_W-1:0] sel_q;

    // Adopt a new select only on the slowest strobe boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sel_q <= '0;
        else if (stb_in[STAGES-1])   sel_q <= sel;
    end

    // Route the chosen strobe to the filter.
    assign stb_out = stb_in[sel_q];

    // R9
    sel_boundary_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stb_in[STAGES-1])) |-> $stable(sel_q)
    );
endmodule

// File: rtl/sf_agree.sv
// sf_agree: delay chain sampled on the strobe, plus an output that follows
// only a unanimous chain.
// Assumes: stb is one cycle wide. din is already synchronized.
module sf_agree #(
    parameter int unsigned DEPTH = sf_pkg::AGREE_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] tap_q;
    logic             out_q;
    logic             all_hi;
    logic             all_lo;

    // Shift a new sample into the chain on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   tap_q <= '0;
        else if (stb) tap_q <= {tap_q[DEPTH-2:0], din};
    end

    // Decode unanimous high and unanimous low.
    always_comb begin
        all_hi = &tap_q;
        all_lo = ~|tap_q;
    end

    // Move the output only to a level that every stage holds.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= 1'b0;
        else if (all_hi) out_q <= 1'b1;
        else if (all_lo) out_q <= 1'b0;
    end

    assign dout = out_q;

    // R3
    taps_on_strobe_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stb)) |-> $stable(tap_q)
    );

    // R4
    out_needs_agreement_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (out_q != $past(out_q)))
            |-> ($past(tap_q) == {DEPTH{out_q}})
    );

    // R1
    reset_clears_chk: assert property (
        @(posedge clk)
        !$past(rst_n) |-> (out_q == 1'b0 && tap_q == '0)
    );
endmodule

// File: rtl/spike_filter.sv
// spike_filter: top of the sampled-clock glitch suppression filter.
// Path: raw line -> synchronizer -> delay chain sampled on the selected
// divided strobe -> agreement output.
// Assumes: a single reference clock; reset is synchronous, active low.
module spike_filter #(
    parameter int unsigned STAGES     = sf_pkg::DIV_STAGES,
    parameter int unsigned SYNC_DEPTH = sf_pkg::SYNC_DEPTH,
    parameter int unsigned TAP_DEPTH  = sf_pkg::AGREE_DEPTH,
    localparam int unsigned SEL_W     = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             line_raw,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             line_clean
);
    logic [STAGES-1:0] stb_all;
    logic              stb_pick;
    logic              line_sync;

    sf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .din   (line_raw),
        .dout  (line_sync)
    );

    sf_strobe_gen #(.STAGES(STAGES)) u_div (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .stb   (stb_all)
    );

    sf_strobe_sel #(.STAGES(STAGES)) u_sel (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .stb_in  (stb_all),
        .sel     (rate_sel),
        .stb_out (stb_pick)
    );

    sf_agree #(.DEPTH(TAP_DEPTH)) u_agree (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .stb   (stb_pick),
        .din   (line_sync),
        .dout  (line_clean)
    );
endmodule

// File: tb/spike_filter_tb.sv
module spike_filter_tb;
    logic       clk_ref = 1'b0;
    logic       rst_n;
    logic       line_raw;
    logic [1:0] rate_sel;
    logic       line_clean;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    spike_filter u_dut (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .line_raw   (line_raw),
        .rate_sel   (rate_sel),
        .line_clean (line_clean)
    );

    // 125 MHz reference clock.
    always #4 clk_ref = ~clk_ref;

    // Vector fields: {sel[1:0], low_pulse, long_pulse, expect_pass}.
    localparam logic [4:0] VEC [16] = '{
        5'b00_0_0_0, 5'b00_1_0_0, 5'b00_0_1_1, 5'b00_1_1_1,
        5'b01_0_0_0, 5'b01_1_0_0, 5'b01_0_1_1, 5'b01_1_1_1,
        5'b10_0_0_0, 5'b10_1_0_0, 5'b10_0_1_1, 5'b10_1_1_1,
        5'b11_0_0_0, 5'b11_1_0_0, 5'b11_0_1_1, 5'b11_1_1_1
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk_ref);
        @(negedge clk_ref);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        line_raw = 1'b1;
        rate_sel = 2'd0;
        repeat (5) cyc();
        // R1: output held at 0 in reset even with the line high.
        check(line_clean == 1'b0, "R1 reset", line_clean, 0);
        rst_n = 1'b1;
        cyc();
        cyc();
        // R1/R3: the output cannot follow the high line immediately after reset.
        check(line_clean == 1'b0, "R1 R3 post-reset", line_clean, 0);

        // Table-driven pulse tests.
        for (int i = 0; i < 16; i++) begin
            logic [4:0] v;
            int p, w, first, win;
            bit base, lvl, pass, seen, stray;
            v     = VEC[i];
            p     = 2 << v[4:3];
            w     = v[1] ? 2 * p : p - 1;
            base  = v[2];
            lvl   = ~base;
            pass  = v[0];
            first = 0;
            seen  = 1'b0;
            stray = 1'b0;
            win   = w + 2 * p + 6;
            rate_sel = v[4:3];
            line_raw = base;
            repeat (64) cyc();
            // R2: each vector starts from the resting level.
            check(line_clean == base, "R2 settle", line_clean, base);
            line_raw = lvl;
            for (int n = 1; n <= win; n++) begin
                cyc();
                if (n == w) line_raw = base;
                if (line_clean == lvl) begin
                    if (!seen) first = n;
                    seen = 1'b1;
                    if (!pass) stray = 1'b1;
                end
            end
            if (!pass) begin
                if (base) check(!stray, "R6 R4 low spike removed", stray, 0);
                else      check(!stray, "R5 R4 high spike removed", stray, 0);
            end else begin
                check(seen, "R7 long pulse passes", seen, 1);
                check(first >= p + 4, "R3 R8 latency lower bound", first, p + 4);
                check(first <= 2 * p + 3, "R8 latency upper bound", first, 2 * p + 3);
                check(line_clean == base, "R7 returns to rest", line_clean, base);
            end
        end

        // R9: select changes on a steady high line cause no output edge.
        begin
            bit moved;
            moved    = 1'b0;
            line_raw = 1'b1;
            repeat (64) cyc();
            check(line_clean == 1'b1, "R9 steady high", line_clean, 1);
            for (int n = 0; n < 120; n++) begin
                if (n % 7 == 0) rate_sel = rate_sel + 2'd1;
                cyc();
                if (line_clean != 1'b1) moved = 1'b1;
            end
            check(!moved, "R9 no edge on select change", moved, 0);
        end

        // R1: a reset in the middle of operation clears a high output.
        rst_n = 1'b0;
        cyc();
        check(line_clean == 1'b0, "R1 mid-run reset", line_clean, 0);
        rst_n = 1'b1;
        cyc();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule